// File: doc/BRIEF.md
# PWM Duty Capture with Open-Loop Drive Polarity

This block takes a single-bit PWM stream from outside the chip and turns it into a drive command for a vibration actuator. Each input period, measured from one rising edge to the next, gives a ratio of high time to total time. That ratio is scaled to an 8-bit strength. The strength is shown on the output only while the PWM mode is enabled and standby is low. The drive holds that value, and is refreshed on every new period, until standby is asserted or the mode is left.

When the open-loop control input is set, the block also produces a square polarity signal. Its period spans 128 input PWM periods, so the drive frequency is the PWM frequency divided by 128. When open-loop is clear, the polarity is held low, because frequency selection belongs to a resonance tracker outside this block.

The input is resynchronised with two flops before edges are detected. If no rising edge arrives for a programmable number of clocks, the measured strength drops to zero.

Top module: `pwm_drive_capture`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, drive_strength, drive_polarity and drive_active are all 0.
- R2: drive_active is 1 exactly when pwm_mode_en was 1 and standby was 0 on the previous clock edge.
- R3: After each rising edge of the input, drive_strength equals floor(H*255/P). Here P is the number of clocks in the most recent complete period between two rising edges, and H is the number of those clocks during which the synchronised input was high.
- R4: While drive_active is 0, drive_strength is 0. Measurement continues, so the latest value appears again once the drive is re-enabled.
- R5: Until two rising edges have been seen after reset or after a timeout, no complete period exists and the measured strength stays 0.
- R6: If no rising edge is seen for TIMEOUT clocks, the measured strength becomes 0. A period of exactly TIMEOUT clocks is still measured.
- R7: With open-loop set and the drive active, drive_polarity starts at 0 and inverts on every HALF_EDGES-th input rising edge (64 by default). One full polarity cycle therefore spans 2*HALF_EDGES input periods.
- R8: With open-loop clear or the drive inactive, drive_polarity is 0 and the rising-edge count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_in | input | 1 | Asynchronous PWM input |
| pwm_mode_en | input | 1 | Selects PWM capture as the drive source |
| standby | input | 1 | Suspends the drive when high |
| open_loop | input | 1 | Enables the divided-frequency polarity output |
| drive_strength | output | 8 | Scaled duty cycle, zero while inactive |
| drive_polarity | output | 1 | Square drive polarity at PWM frequency / 128 |
| drive_active | output | 1 | Drive enabled (registered) |

## Verification
The bench builds the block with CNT_W = 12 and TIMEOUT = 1000 and keeps the default HALF_EDGES of 64. With these values the timeout, and the case of a period exactly equal to it, can be reached in about a thousand clocks. Short 20-clock input periods let two complete polarity cycles, and a restart after open-loop is cleared, fit in a few thousand clocks. The duty vectors cover narrow, half, wide and odd-length periods, so truncation in the scaling shows up.

// File: rtl/pwm_drive_pkg.sv
// Shared widths and types for the PWM capture drive.
// Assumes an 8-bit strength whose full scale is 255.
package pwm_drive_pkg;
    localparam int STRENGTH_W   = 8;
    localparam int STRENGTH_MAX = (1 << STRENGTH_W) - 1;
    typedef logic [STRENGTH_W-1:0] strength_t;
endpackage

// File: rtl/pwm_in_sync.sv
// Two-flop synchroniser followed by a rising-edge detector.
// Assumes pwm_async may change at any time relative to clk.
module pwm_in_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_async,
    output logic level,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    // Resynchronise the input and keep one cycle of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pwm_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
endmodule

// File: rtl/pwm_duty_meter.sv
// Counts total and high clocks between rising edges. On each edge it scales
// the high/total ratio of the finished period to a strength value.
// Assumes TIMEOUT fits in CNT_W bits. Counters saturate at TIMEOUT.
module pwm_duty_meter
    import pwm_drive_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TIMEOUT = 50000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  logic      rise,
    output strength_t duty
);
    localparam int            PROD_W = CNT_W + STRENGTH_W;
    localparam logic [CNT_W-1:0] TO_C = CNT_W'(TIMEOUT);

    logic [CNT_W-1:0] period_cnt, high_cnt;
    logic             valid_q;
    logic [PROD_W-1:0] num, den;
    strength_t        ratio;

    // Scale high/total of the period that ends at this edge.
    always_comb begin
        num   = PROD_W'(high_cnt) * PROD_W'(STRENGTH_MAX);
        den   = (period_cnt == '0) ? PROD_W'(1) : PROD_W'(period_cnt);
        ratio = STRENGTH_W'(num / den);
    end

    // Period and high-time counting, result latch and timeout handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_cnt <= '0;
            high_cnt   <= '0;
            valid_q    <= 1'b0;
            duty       <= '0;
        end else if (rise) begin
            period_cnt <= CNT_W'(1);
            high_cnt   <= CNT_W'(1);
            valid_q    <= 1'b1;
            if (valid_q) duty <= ratio;
        end else if (period_cnt == TO_C) begin
            valid_q <= 1'b0;
            duty    <= '0;
        end else begin
            period_cnt <= period_cnt + CNT_W'(1);
            high_cnt   <= high_cnt + CNT_W'(level);
        end
    end

    assert_high_le_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        high_cnt <= period_cnt);
    assert_timeout_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise && period_cnt == TO_C) |=> (duty == '0));
    assert_no_period_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_q && $past(rst_n)) |-> (duty == '0));
endmodule

// File: rtl/pwm_polarity_div.sv
// Toggles a polarity flag once every HALF_EDGES rising edges, which divides
// the input frequency by 2*HALF_EDGES. Assumes HALF_EDGES >= 1.
// Flag and count are cleared whenever run is low.
module pwm_polarity_div #(
    parameter int HALF_EDGES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic rise,
    output logic pol
);
    localparam int            EW   = $clog2(HALF_EDGES + 1);
    localparam logic [EW-1:0] LAST = EW'(HALF_EDGES - 1);

    logic [EW-1:0] edge_cnt;

    // Count rising edges and invert the polarity at the end of each half cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            edge_cnt <= '0;
            pol      <= 1'b0;
        end else if (rise) begin
            if (edge_cnt == LAST) begin
                edge_cnt <= '0;
                pol      <= ~pol;
            end else begin
                edge_cnt <= edge_cnt + EW'(1);
            end
        end
    end

    assert_pol_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pol);
    assert_pol_only_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise) |=> ($stable(pol) || !pol));
endmodule

// File: rtl/pwm_drive_capture.sv
// Top level: captures the PWM duty as a drive strength and, in open-loop
// mode, produces a polarity signal at the PWM frequency divided by 128.
// Assumes a synchronous active-low reset. All control inputs are synchronous to clk.
module pwm_drive_capture
    import pwm_drive_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int TIMEOUT    = 50000,
    parameter int HALF_EDGES = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwm_in,
    input  logic                  pwm_mode_en,
    input  logic                  standby,
    input  logic                  open_loop,
    output logic [STRENGTH_W-1:0] drive_strength,
    output logic                  drive_polarity,
    output logic                  drive_active
);
    logic      level, rise, active_q, pol;
    strength_t duty;

    pwm_in_sync u_sync (
        .clk(clk), .rst_n(rst_n), .pwm_async(pwm_in), .level(level), .rise(rise)
    );

    pwm_duty_meter #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_meter (
        .clk(clk), .rst_n(rst_n), .level(level), .rise(rise), .duty(duty)
    );

    pwm_polarity_div #(.HALF_EDGES(HALF_EDGES)) u_div (
        .clk(clk), .rst_n(rst_n), .run(open_loop && active_q), .rise(rise), .pol(pol)
    );

    // Register the drive-enable condition from mode and standby.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= pwm_mode_en && !standby;
    end

    assign drive_active   = active_q;
    assign drive_strength = active_q ? duty : '0;
    assign drive_polarity = pol;

    assert_enable_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_mode_en && !standby) |=> drive_active);
    assert_disable_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_mode_en && !standby) |=> !drive_active);
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode_en || standby) |=> (drive_strength == '0));
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (drive_strength == '0 && !drive_polarity && !drive_active));
endmodule

// File: tb/pwm_drive_capture_bench.sv
module pwm_drive_capture_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic       pwm_mode_en = 1'b0;
    logic       standby = 1'b0;
    logic       open_loop = 1'b0;
    logic [7:0] drive_strength;
    logic       drive_polarity, drive_active;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // {high clocks, period clocks, expected floor(high*255/period)}
    localparam int NV = 8;
    localparam int VEC [NV][3] = '{
        '{10, 40, 63}, '{20, 40, 127}, '{30, 40, 191}, '{1, 40, 6},
        '{39, 40, 248}, '{50, 100, 127}, '{7, 16, 111}, '{90, 250, 91}
    };

    always #4 clk = ~clk;

    pwm_drive_capture #(.CNT_W(12), .TIMEOUT(1000), .HALF_EDGES(64)) u_pwm_drive_capture (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .pwm_mode_en(pwm_mode_en),
        .standby(standby), .open_loop(open_loop), .drive_strength(drive_strength),
        .drive_polarity(drive_polarity), .drive_active(drive_active)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic periods(input int h, input int p, input int n);
        for (int i = 0; i < n; i++) begin
            pwm_in = 1'b1;
            repeat (h) @(negedge clk);
            pwm_in = 1'b0;
            repeat (p - h) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check_eq("R1 strength", drive_strength, 0);
        check_eq("R1 polarity", drive_polarity, 0);
        check_eq("R1 active", drive_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 first cycle strength", drive_strength, 0);

        pwm_mode_en = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R2 enable", drive_active, 1);

        periods(20, 40, 1);
        check_eq("R5 single edge", drive_strength, 0);

        // Duty vector table (R3)
        for (int v = 0; v < NV; v++) begin
            periods(VEC[v][0], VEC[v][1], 3);
            check_eq($sformatf("R3 vector %0d", v), drive_strength, VEC[v][2]);
        end
        check_eq("R8 closed-loop polarity", drive_polarity, 0);

        // Standby and mode gating (R2, R4)
        standby = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R2 standby", drive_active, 0);
        check_eq("R4 standby strength", drive_strength, 0);
        periods(20, 40, 3);
        check_eq("R4 still zero", drive_strength, 0);
        standby = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R4 resumes", drive_strength, 127);
        pwm_mode_en = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R2 mode off", drive_active, 0);
        check_eq("R4 mode off strength", drive_strength, 0);
        pwm_mode_en = 1'b1;
        repeat (2) @(negedge clk);

        // Timeout (R6, R5)
        repeat (1100) @(negedge clk);
        check_eq("R6 timeout", drive_strength, 0);
        periods(20, 40, 1);
        check_eq("R5 after timeout", drive_strength, 0);
        periods(20, 40, 2);
        check_eq("R3 after timeout", drive_strength, 127);
        periods(450, 900, 3);
        check_eq("R6 below timeout", drive_strength, 127);
        periods(250, 1000, 3);
        check_eq("R6 period equal to timeout", drive_strength, 63);

        // Open-loop polarity (R7, R8)
        open_loop = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R7 start", drive_polarity, 0);
        periods(10, 20, 63);
        check_eq("R7 edge 63", drive_polarity, 0);
        periods(10, 20, 1);
        check_eq("R7 edge 64", drive_polarity, 1);
        periods(10, 20, 63);
        check_eq("R7 edge 127", drive_polarity, 1);
        periods(10, 20, 1);
        check_eq("R7 edge 128", drive_polarity, 0);
        check_eq("R3 during open loop", drive_strength, 127);
        periods(10, 20, 64);
        check_eq("R7 edge 192", drive_polarity, 1);
        open_loop = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R8 cleared", drive_polarity, 0);
        periods(10, 20, 10);
        check_eq("R8 held", drive_polarity, 0);
        open_loop = 1'b1;
        repeat (2) @(negedge clk);
        periods(10, 20, 63);
        check_eq("R8 restart edge 63", drive_polarity, 0);
        periods(10, 20, 1);
        check_eq("R8 restart edge 64", drive_polarity, 1);

        // Reset during operation (R1)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R1 mid reset strength", drive_strength, 0);
        check_eq("R1 mid reset polarity", drive_polarity, 0);
        check_eq("R1 mid reset active", drive_active, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule